// File: doc/BRIEF.md
# Snooping MESI Line Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache that sits on a shared snooping bus. Each line holds a tag and one of four states: Invalid, Shared, Exclusive or Modified. Processor reads and writes are looked up against this array. A hit either completes locally or, for a write to a Shared copy, asks the bus for ownership. A miss asks the bus for the line, and writes back a dirty victim first when one is in the way.

In parallel, the block watches the bus for reads and read-for-ownership requests from other caches. It demotes or invalidates its own copy and signals a flush when it holds the only up-to-date data. For every snooped read that hits a valid copy, it pulls a wired-OR shared line. On its own read fills, it samples that line a fixed number of cycles after its address cycle. When no other cache answers, the line is installed Exclusive, so a later write can skip the bus.

Bus arbitration, the data RAM and the actual data movement sit outside the block. The block only raises a request with a command and an address, and waits for a grant.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready` is 1, and `bus_req`, `cpu_done`, `flush_out` and `shared_out` are 0.
- R2: A read that misses raises `bus_req` with `bus_cmd` = 01 (bus read) and the requested address. `shared_in` is sampled VOTE_DELAY cycles after the grant edge. The line fills Exclusive (10) if `shared_in` was 0 and Shared (01) if it was 1, and `cpu_done_state` reports the state.
- R3: A write that misses, or that hits a Shared line, raises `bus_cmd` = 10 (read for ownership). On the grant edge the line becomes Modified (11), and `cpu_done` pulses in the next cycle.
- R4: A read hitting any valid line, or a write hitting Modified, completes one cycle after acceptance with no bus request. The line state is unchanged.
- R5: A write hitting an Exclusive line completes one cycle after acceptance with no bus request, and the line becomes Modified.
- R6: A snooped bus read (`snp_cmd` = 0) that hits a Modified line pulses `flush_out` for one cycle with `flush_addr` equal to the snooped address. The line becomes Shared.
- R7: A snooped bus read that hits an Exclusive line makes it Shared without a flush.
- R8: A snooped read for ownership (`snp_cmd` = 1) that hits a line invalidates it. It flushes only when the line was Modified.
- R9: A snooped bus read that hits any valid line drives `shared_out` high for VOTE_DELAY cycles starting the cycle after the snoop. A snoop that misses on tag leaves `shared_out`, `flush_out` and the line untouched.
- R10: A miss whose victim line is Modified first issues `bus_cmd` = 11 (write-back) with the victim address. After that grant it issues the fill request. A Shared or Exclusive victim is dropped with no bus traffic.
- R11: While `bus_req` is high and not granted, `bus_cmd` and `bus_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address: upper bits tag, low IDX_W bits index |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_done_state | output | 2 | Line state after the completed request |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read-for-ownership, 11 write-back |
| bus_addr | output | ADDR_W | Address of the pending transaction |
| bus_gnt | input | 1 | Grant; the edge where it meets `bus_req` is the address cycle |
| shared_in | input | 1 | Wired-OR shared vote as seen on the bus |
| shared_out | output | 1 | This cache's contribution to the shared vote |
| snp_valid | input | 1 | A foreign bus transaction is being snooped |
| snp_cmd | input | 1 | 0 = bus read, 1 = read-for-ownership |
| snp_addr | input | ADDR_W | Snooped line address |
| flush_out | output | 1 | One-cycle pulse: this cache must supply dirty data |
| flush_addr | output | ADDR_W | Address of the line being flushed |

## Verification
The checks assume that `bus_gnt` only rises while `bus_req` is high, and that the bus never presents this cache's own transaction on the snoop port. They also assume that a snoop and a processor-side array update never hit the same index in the same cycle. The stimulus holds to this by issuing snoops only while the controller is idle and no processor request is being presented. It grants a pending request only after one deliberate wait cycle. It drives `shared_in` only between the grant edge and the sampling edge of the controller's own read.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'b00,
    BC_RD   = 2'b01,
    BC_RDX  = 2'b10,
    BC_WB   = 2'b11
  } bus_cmd_t;

  typedef enum logic [1:0] {
    PF_IDLE = 2'b00,
    PF_BUS  = 2'b01,
    PF_VOTE = 2'b10
  } pfsm_t;

  // state a valid line takes after a foreign transaction is observed
  function automatic line_st_t snoop_next(line_st_t cur, logic is_rdx);
    if (is_rdx)
      return ST_I;
    else if (cur == ST_I)
      return ST_I;
    else
      return ST_S;
  endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] p_idx,
  output line_st_t         p_st,
  output logic [TAG_W-1:0] p_tag,
  input  logic             p_we,
  input  logic [IDX_W-1:0] p_widx,
  input  logic [TAG_W-1:0] p_wtag,
  input  line_st_t         p_wst,
  input  logic [IDX_W-1:0] s_idx,
  output line_st_t         s_st,
  output logic [TAG_W-1:0] s_tag,
  input  logic             s_we,
  input  logic [IDX_W-1:0] s_widx,
  input  line_st_t         s_wst
);

  localparam int LINES = 1 << IDX_W;

  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          st_q[g]  <= ST_I;
          tag_q[g] <= '0;
        end else if (s_we && s_widx == IDX_W'(g)) begin
          st_q[g] <= s_wst;
        end else if (p_we && p_widx == IDX_W'(g)) begin
          st_q[g]  <= p_wst;
          tag_q[g] <= p_wtag;
        end
      end
    end
  endgenerate

  assign p_st  = st_q[p_idx];
  assign p_tag = tag_q[p_idx];
  assign s_st  = st_q[s_idx];
  assign s_tag = tag_q[s_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 2,
  parameter int VOTE_DELAY = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snp_valid,
  input  logic                    snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic [IDX_W-1:0]        s_idx,
  input  line_st_t                s_st,
  input  logic [ADDR_W-IDX_W-1:0] s_tag,
  output logic                    s_we,
  output logic [IDX_W-1:0]        s_widx,
  output line_st_t                s_wst,
  output logic                    shared_out,
  output logic                    flush_out,
  output logic [ADDR_W-1:0]       flush_addr
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CNT_W = $clog2(VOTE_DELAY + 1);

  logic             hit;
  logic             shr_q;
  logic [CNT_W-1:0] shr_cnt_q;
  logic             flush_q;
  logic [ADDR_W-1:0] flush_addr_q;

  assign s_idx  = snp_addr[IDX_W-1:0];
  assign hit    = snp_valid && (s_st != ST_I) &&
                  (s_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign s_we   = hit;
  assign s_widx = s_idx;
  assign s_wst  = snoop_next(s_st, snp_cmd);

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q      <= 1'b0;
      flush_addr_q <= '0;
      shr_q        <= 1'b0;
      shr_cnt_q    <= '0;
    end else begin
      flush_q <= hit && (s_st == ST_M);
      if (hit && s_st == ST_M)
        flush_addr_q <= snp_addr;
      if (hit && !snp_cmd) begin
        shr_q     <= 1'b1;
        shr_cnt_q <= CNT_W'(VOTE_DELAY - 1);
      end else if (shr_cnt_q != '0) begin
        shr_cnt_q <= shr_cnt_q - 1'b1;
      end else begin
        shr_q <= 1'b0;
      end
    end
  end

  assign shared_out = shr_q;
  assign flush_out  = flush_q;
  assign flush_addr = flush_addr_q;

  logic unused_tagw;
  assign unused_tagw = ^{TAG_W{1'b0}};

endmodule

// File: rtl/mesi_proc_ctrl.sv
module mesi_proc_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 2,
  parameter int VOTE_DELAY = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req_valid,
  input  logic                    cpu_req_write,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  output logic                    cpu_ready,
  output logic                    cpu_done,
  output line_st_t                cpu_done_state,
  output logic                    bus_req,
  output bus_cmd_t                bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_gnt,
  input  logic                    shared_in,
  output logic [IDX_W-1:0]        p_idx,
  input  line_st_t                p_st,
  input  logic [ADDR_W-IDX_W-1:0] p_tag,
  output logic                    p_we,
  output logic [IDX_W-1:0]        p_widx,
  output logic [ADDR_W-IDX_W-1:0] p_wtag,
  output line_st_t                p_wst
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CNT_W = $clog2(VOTE_DELAY + 1);

  pfsm_t             fsm_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  line_st_t          done_st_q;
  logic              breq_q;
  bus_cmd_t          bcmd_q;
  logic [ADDR_W-1:0] baddr_q;

  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic              local_ok;

  assign p_idx    = (fsm_q == PF_IDLE) ? cpu_req_addr[IDX_W-1:0]
                                       : addr_q[IDX_W-1:0];
  assign req_tag  = cpu_req_addr[ADDR_W-1:IDX_W];
  assign hit      = (p_st != ST_I) && (p_tag == req_tag);
  assign local_ok = hit && !(p_st == ST_S && cpu_req_write);

  always_comb begin
    p_we   = 1'b0;
    p_widx = p_idx;
    p_wtag = addr_q[ADDR_W-1:IDX_W];
    p_wst  = ST_I;
    unique case (fsm_q)
      PF_IDLE: begin
        p_wtag = req_tag;
        if (cpu_req_valid) begin
          if (hit && p_st == ST_E && cpu_req_write) begin
            p_we  = 1'b1;
            p_wst = ST_M;
          end else if (!hit && (p_st == ST_S || p_st == ST_E)) begin
            p_we  = 1'b1;
            p_wst = ST_I;
            p_wtag = p_tag;
          end
        end
      end
      PF_BUS: begin
        if (bus_gnt && bcmd_q == BC_WB) begin
          p_we  = 1'b1;
          p_wst = ST_I;
        end else if (bus_gnt && bcmd_q == BC_RDX) begin
          p_we  = 1'b1;
          p_wst = ST_M;
        end
      end
      PF_VOTE: begin
        if (cnt_q == '0) begin
          p_we  = 1'b1;
          p_wst = shared_in ? ST_S : ST_E;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= PF_IDLE;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      done_st_q <= ST_I;
      breq_q    <= 1'b0;
      bcmd_q    <= BC_NONE;
      baddr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm_q)
        PF_IDLE: begin
          if (cpu_req_valid) begin
            addr_q <= cpu_req_addr;
            wr_q   <= cpu_req_write;
            if (local_ok) begin
              done_q    <= 1'b1;
              done_st_q <= cpu_req_write ? ST_M : p_st;
            end else if (!hit && p_st == ST_M) begin
              fsm_q   <= PF_BUS;
              breq_q  <= 1'b1;
              bcmd_q  <= BC_WB;
              baddr_q <= {p_tag, cpu_req_addr[IDX_W-1:0]};
            end else begin
              fsm_q   <= PF_BUS;
              breq_q  <= 1'b1;
              bcmd_q  <= cpu_req_write ? BC_RDX : BC_RD;
              baddr_q <= cpu_req_addr;
            end
          end
        end
        PF_BUS: begin
          if (bus_gnt) begin
            unique case (bcmd_q)
              BC_WB: begin
                bcmd_q  <= wr_q ? BC_RDX : BC_RD;
                baddr_q <= addr_q;
              end
              BC_RDX: begin
                fsm_q     <= PF_IDLE;
                breq_q    <= 1'b0;
                bcmd_q    <= BC_NONE;
                done_q    <= 1'b1;
                done_st_q <= ST_M;
              end
              default: begin
                fsm_q  <= PF_VOTE;
                breq_q <= 1'b0;
                bcmd_q <= BC_NONE;
                cnt_q  <= CNT_W'(VOTE_DELAY - 1);
              end
            endcase
          end
        end
        PF_VOTE: begin
          if (cnt_q == '0) begin
            fsm_q     <= PF_IDLE;
            done_q    <= 1'b1;
            done_st_q <= shared_in ? ST_S : ST_E;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: fsm_q <= PF_IDLE;
      endcase
    end
  end

  assign cpu_ready      = (fsm_q == PF_IDLE);
  assign cpu_done       = done_q;
  assign cpu_done_state = done_st_q;
  assign bus_req        = breq_q;
  assign bus_cmd        = bcmd_q;
  assign bus_addr       = baddr_q;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 2,
  parameter int VOTE_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [1:0]        cpu_done_state,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              shared_in,
  output logic              shared_out,
  input  logic              snp_valid,
  input  logic              snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush_out,
  output logic [ADDR_W-1:0] flush_addr
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] p_idx, p_widx, s_idx, s_widx;
  line_st_t         p_st, p_wst, s_st, s_wst;
  logic [TAG_W-1:0] p_tag, p_wtag, s_tag;
  logic             p_we, s_we;
  line_st_t         done_st;
  bus_cmd_t         bcmd;

  mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .p_idx  (p_idx),
    .p_st   (p_st),
    .p_tag  (p_tag),
    .p_we   (p_we),
    .p_widx (p_widx),
    .p_wtag (p_wtag),
    .p_wst  (p_wst),
    .s_idx  (s_idx),
    .s_st   (s_st),
    .s_tag  (s_tag),
    .s_we   (s_we),
    .s_widx (s_widx),
    .s_wst  (s_wst)
  );

  mesi_proc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VOTE_DELAY(VOTE_DELAY)) u_proc (
    .clk            (clk),
    .rst            (rst),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_addr   (cpu_req_addr),
    .cpu_ready      (cpu_ready),
    .cpu_done       (cpu_done),
    .cpu_done_state (done_st),
    .bus_req        (bus_req),
    .bus_cmd        (bcmd),
    .bus_addr       (bus_addr),
    .bus_gnt        (bus_gnt),
    .shared_in      (shared_in),
    .p_idx          (p_idx),
    .p_st           (p_st),
    .p_tag          (p_tag),
    .p_we           (p_we),
    .p_widx         (p_widx),
    .p_wtag         (p_wtag),
    .p_wst          (p_wst)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VOTE_DELAY(VOTE_DELAY)) u_snoop (
    .clk        (clk),
    .rst        (rst),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_addr   (snp_addr),
    .s_idx      (s_idx),
    .s_st       (s_st),
    .s_tag      (s_tag),
    .s_we       (s_we),
    .s_widx     (s_widx),
    .s_wst      (s_wst),
    .shared_out (shared_out),
    .flush_out  (flush_out),
    .flush_addr (flush_addr)
  );

  assign cpu_done_state = done_st;
  assign bus_cmd        = bcmd;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic [1:0]        cpu_done_state,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              shared_out,
  input logic              snp_valid,
  input logic              snp_cmd,
  input logic              flush_out
);

  assert_cmd_present_R2: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_cmd != 2'b00);

  assert_read_waits_vote_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'b01) |=> !cpu_done);

  assert_rdx_fills_modified_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'b10) |=> (cpu_done && cpu_done_state == 2'b11));

  assert_done_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (cpu_ready && !bus_req));

  assert_flush_after_snoop_R6: assert property (@(posedge clk) disable iff (rst)
    flush_out |-> $past(snp_valid));

  assert_shared_after_read_snoop_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(shared_out) |-> $past(snp_valid && !snp_cmd));

  assert_wb_then_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'b11) |=> (bus_req && bus_cmd != 2'b11));

  assert_hold_until_grant_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cpu_ready      (cpu_ready),
  .cpu_done       (cpu_done),
  .cpu_done_state (cpu_done_state),
  .bus_req        (bus_req),
  .bus_cmd        (bus_cmd),
  .bus_addr       (bus_addr),
  .bus_gnt        (bus_gnt),
  .shared_out     (shared_out),
  .snp_valid      (snp_valid),
  .snp_cmd        (snp_cmd),
  .flush_out      (flush_out)
);

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;

  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int VDLY   = 2;

  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_RDX = 2'b10, C_WB = 2'b11;
  localparam logic [1:0] S_I = 2'b00, S_S = 2'b01, S_E = 2'b10, S_M = 2'b11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic              cpu_ready, cpu_done;
  logic [1:0]        cpu_done_state;
  logic              bus_req;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_gnt = 1'b0;
  logic              shared_in = 1'b0;
  logic              shared_out;
  logic              snp_valid = 1'b0;
  logic              snp_cmd = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              flush_out;
  logic [ADDR_W-1:0] flush_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VOTE_DELAY(VDLY)) uut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_done_state(cpu_done_state), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_gnt(bus_gnt), .shared_in(shared_in),
    .shared_out(shared_out), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .flush_out(flush_out), .flush_addr(flush_addr)
  );

  // vector: {write[11], addr[10:5], shared_in[4], expected cmd[3:2], expected state[1:0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 6'h01, 1'b0, C_RD,   S_E},
    {1'b0, 6'h01, 1'b0, C_NONE, S_E},
    {1'b1, 6'h01, 1'b0, C_NONE, S_M},
    {1'b0, 6'h01, 1'b0, C_NONE, S_M},
    {1'b1, 6'h01, 1'b0, C_NONE, S_M},
    {1'b0, 6'h02, 1'b1, C_RD,   S_S},
    {1'b0, 6'h02, 1'b0, C_NONE, S_S},
    {1'b1, 6'h02, 1'b0, C_RDX,  S_M},
    {1'b1, 6'h03, 1'b0, C_RDX,  S_M},
    {1'b0, 6'h00, 1'b1, C_RD,   S_S},
    {1'b0, 6'h04, 1'b0, C_RD,   S_E},
    {1'b0, 6'h00, 1'b0, C_RD,   S_E}
  };
  string vreq [NV] = '{"R2", "R4", "R5", "R4", "R4", "R2",
                       "R4", "R3", "R3", "R2", "R10", "R10"};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expects a pending request, waits one ungranted cycle, then grants it
  task automatic grant_expect(input logic [1:0] ecmd, input logic [ADDR_W-1:0] ea,
                              input string req);
    chk(bus_req == 1'b1, req, "bus_req raised", bus_req, 1);
    chk(bus_cmd == ecmd, req, "bus_cmd", bus_cmd, ecmd);
    chk(bus_addr == ea, req, "bus_addr", bus_addr, ea);
    tick();
    chk(bus_req && bus_cmd == ecmd && bus_addr == ea, "R11", "held while ungranted",
        {bus_req, bus_cmd}, {1'b1, ecmd});
    bus_gnt = 1'b1;
    tick();
    bus_gnt = 1'b0;
  endtask

  task automatic finish_rd(input bit shr, input logic [1:0] est, input string req);
    chk(cpu_done == 1'b0, req, "no completion before vote", cpu_done, 0);
    shared_in = shr;
    for (int k = 1; k < VDLY; k++) begin
      tick();
      chk(cpu_done == 1'b0, req, "no completion during vote", cpu_done, 0);
    end
    tick();
    shared_in = 1'b0;
    chk(cpu_done == 1'b1, req, "done after vote", cpu_done, 1);
    chk(cpu_done_state == est, req, "fill state", cpu_done_state, est);
  endtask

  task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a, input bit shr,
                        input logic [1:0] ecmd, input logic [1:0] est, input string req);
    while (!cpu_ready) tick();
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    tick();
    cpu_req_valid = 1'b0;
    if (ecmd == C_NONE) begin
      chk(bus_req == 1'b0, req, "no bus request on hit", bus_req, 0);
      chk(cpu_done == 1'b1, req, "hit done", cpu_done, 1);
      chk(cpu_done_state == est, req, "hit state", cpu_done_state, est);
    end else begin
      grant_expect(ecmd, a, req);
      if (ecmd == C_RDX) begin
        chk(cpu_done == 1'b1, req, "done after ownership", cpu_done, 1);
        chk(cpu_done_state == est, req, "ownership state", cpu_done_state, est);
      end else begin
        finish_rd(shr, est, req);
      end
    end
    tick();
  endtask

  task automatic snoop(input bit rdx, input logic [ADDR_W-1:0] a,
                       input bit eflush, input bit eshared, input string req);
    snp_valid = 1'b1;
    snp_cmd   = rdx;
    snp_addr  = a;
    tick();
    snp_valid = 1'b0;
    chk(flush_out == eflush, req, "flush pulse", flush_out, eflush);
    if (eflush)
      chk(flush_addr == a, req, "flush address", flush_addr, a);
    chk(shared_out == eshared, req, "shared vote", shared_out, eshared);
    tick();
    chk(flush_out == 1'b0, req, "flush lasts one cycle", flush_out, 0);
    chk(shared_out == eshared, req, "shared held", shared_out, eshared);
    tick();
    chk(shared_out == 1'b0, "R9", "shared released", shared_out, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    // R1: reset state
    chk(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
    chk({bus_req, cpu_done, flush_out, shared_out} == 4'b0, "R1", "outputs quiet",
        {bus_req, cpu_done, flush_out, shared_out}, 0);

    for (int i = 0; i < NV; i++)
      cpu_op(VEC[i][11], VEC[i][10:5], VEC[i][4], VEC[i][3:2], VEC[i][1:0], vreq[i]);

    // R6: snooped read on Modified 0x01 -> flush, becomes Shared (write then needs ownership)
    snoop(1'b0, 6'h01, 1'b1, 1'b1, "R6");
    cpu_op(1'b1, 6'h01, 1'b0, C_RDX, S_M, "R6");

    // R8: read-for-ownership on Modified -> flush, Invalid (read then misses)
    snoop(1'b1, 6'h01, 1'b1, 1'b0, "R8");
    cpu_op(1'b0, 6'h01, 1'b0, C_RD, S_E, "R8");

    // R7: snooped read on Exclusive -> Shared, no flush
    snoop(1'b0, 6'h01, 1'b0, 1'b1, "R7");
    cpu_op(1'b1, 6'h01, 1'b0, C_RDX, S_M, "R7");

    // R8: read-for-ownership on Exclusive and on Shared -> Invalid, no flush
    snoop(1'b1, 6'h00, 1'b0, 1'b0, "R8");
    cpu_op(1'b0, 6'h00, 1'b1, C_RD, S_S, "R8");
    snoop(1'b1, 6'h00, 1'b0, 1'b0, "R8");
    cpu_op(1'b0, 6'h00, 1'b0, C_RD, S_E, "R8");

    // R9: snoop with mismatching tag leaves line 0x01 Modified and votes nothing
    snoop(1'b0, 6'h05, 1'b0, 1'b0, "R9");
    cpu_op(1'b0, 6'h01, 1'b0, C_NONE, S_M, "R9");

    // R10: miss on 0x07 evicts dirty 0x03 with a write-back first
    cpu_req_valid = 1'b1;
    cpu_req_write = 1'b0;
    cpu_req_addr  = 6'h07;
    tick();
    cpu_req_valid = 1'b0;
    grant_expect(C_WB, 6'h03, "R10");
    chk(cpu_done == 1'b0, "R10", "no completion after write-back", cpu_done, 0);
    grant_expect(C_RD, 6'h07, "R10");
    finish_rd(1'b0, S_E, "R10");
    tick();
    cpu_op(1'b0, 6'h03, 1'b0, C_RD, S_E, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule